// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Frozen Arbitration

The block gathers a set of peripheral request lines, captures each one either on its rising edge or as a live level, and gates the result with a per-source disable mask. Every source carries its own small configuration word: a five-bit priority, the capture mode, and a flag that selects one of two request paths. These are the normal interrupt path and the fast interrupt path. Each path runs its own arbiter. The arbiter picks the best enabled pending source on that path and holds it. The path's request output stays high, and the chosen source number can be read through a register, until software starts a new round for that path.

Software drives the block over a small 16-bit register bus. Writes are single-cycle strobes and reads are combinational. A new round is started by a write to a control register. That write also acknowledges the held winner, which clears that winner's edge-captured request. The next arbitration then takes place one clock later. The two paths are re-armed separately, so a long fast-interrupt service does not disturb the normal interrupt that is held, and the reverse is also true.

Top module: `prio_intc`

## Requirements
- R1: After reset both mask registers (offset 0x08 for sources 0-15, offset 0x0A for sources 16-31) read 0xFFFF. Both pending registers (0x00, 0x02) read 0. Both winner registers (0x10 normal, 0x12 fast) and the control register (0x14) read 0. Both request outputs are low.
- R2: Source n is reported and masked at bit n of the low register of each pair when n < 16, and at bit n-16 of the high register otherwise. A mask bit of 1 keeps the source out of arbitration and a 0 lets it take part. A winner is held on the first clock edge at which an enabled, pending source exists on an idle path.
- R3: Source n has a configuration register at offset 0x20 + 2n. Bits 6:2 hold the priority, bit 1 selects edge capture (1) or level capture (0), and bit 0 routes the source to the fast path (1) or the normal path (0). Bits 15:7 read 0.
- R4: An edge-mode source becomes pending on the clock edge that samples its input high after it was sampled low, and it stays pending after the input falls. A level-mode source's pending bit equals its current input.
- R5: A write to a pending register keeps the edge-captured bits where the written data is 1 and clears them where it is 0, so writing zero clears them all.
- R6: Among the candidates on a path, the lowest priority value wins. On equal priority the lower source number wins.
- R7: The winner register of a path holds the held source number in bits 4:0. It reads 0 while that path holds no winner, and the path's output is high exactly while a winner is held.
- R8: A held winner stays unchanged, even if a better source arrives or the winner's own request goes away, until its path is re-armed.
- R9: Writing 1 to control bit 0 (normal) or bit 1 (fast) drops that path's output in the next cycle, clears the held winner's edge-captured bit, and arbitrates again one clock later. The other path is unaffected, and the control register reads 0.
- R10: Sources at or above the implemented count (parameter NSRC) read 0 in the pending registers, ignore writes to their configuration registers (which read 0), and never win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Peripheral request lines |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register addressed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal-path request, high while a winner is held |
| fiq_o | output | 1 | Fast-path request, high while a winner is held |

## Verification
A level-mode source is visible in its pending register in the same cycle its input rises. An edge-mode source appears one edge later, and a path's held winner and output follow one edge after the source becomes an enabled candidate. A register write takes effect at the edge that ends its strobe. After a re-arm write, the output reads low in the cycle straight after that edge and shows the next winner one cycle after that. The bench drives on the falling edge and samples each result exactly at the falling edge where this latency count puts it. Where a latency matters, it also checks the earlier falling edge and expects the old value there.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int PRIO_W   = 5;
    localparam int ID_W     = 5;
    localparam int REG_W    = 16;
    localparam int MAX_SRC  = 32;

    // register byte offsets
    localparam logic [7:0] OFS_PEND_LO = 8'h00;
    localparam logic [7:0] OFS_PEND_HI = 8'h02;
    localparam logic [7:0] OFS_MASK_LO = 8'h08;
    localparam logic [7:0] OFS_MASK_HI = 8'h0A;
    localparam logic [7:0] OFS_NUM_N   = 8'h10;
    localparam logic [7:0] OFS_NUM_F   = 8'h12;
    localparam logic [7:0] OFS_CTRL    = 8'h14;
    localparam logic [7:0] OFS_CFG     = 8'h20;

    typedef enum logic {
        ROUTE_NORM = 1'b0,
        ROUTE_FAST = 1'b1
    } route_e;

    // packed so that the struct bits line up with register bits 6:0
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              edge_sel;
        route_e            route;
    } src_cfg_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } win_t;

    function automatic logic [REG_W-1:0] cfg_to_reg(input src_cfg_t c);
        return {{(REG_W-$bits(src_cfg_t)){1'b0}}, c};
    endfunction

    function automatic src_cfg_t reg_to_cfg(input logic [REG_W-1:0] d);
        src_cfg_t c;
        c.prio     = d[6:2];
        c.edge_sel = d[1];
        c.route    = route_e'(d[0]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] win_to_reg(input win_t w);
        return w.valid ? {{(REG_W-ID_W){1'b0}}, w.id} : '0;
    endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture
    import intc_pkg::*;
#(
    parameter int NSRC = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] keep,
    input  logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] pending
);

    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] epend_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i]  <= 1'b0;
                epend_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= src_in[i];
                if (edge_sel[i] && src_in[i] && !prev_q[i]) begin
                    epend_q[i] <= 1'b1;
                end else if (!edge_sel[i] || !keep[i] || ack[i]) begin
                    epend_q[i] <= 1'b0;
                end
            end
        end

        assign pending[i] = edge_sel[i] ? epend_q[i] : src_in[i];

        // R4: a sampled rising edge in edge mode always leaves the bit set
        p_edge_latch_r4: assert property (@(posedge clk) disable iff (rst)
            (edge_sel[i] && src_in[i] && !prev_q[i]) |=> epend_q[i]);

        // R5: a zero in the write data with no new edge clears the bit
        p_sw_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (!keep[i] && !(src_in[i] && !prev_q[i])) |=> !epend_q[i]);
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NSRC = 24
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output win_t                        win
);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        win       = '0;
        best_prio = '1;
        for (int i = 0; i < NSRC; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i] && (!win.valid || prio[i] < best_prio)) begin
                win.valid = 1'b1;
                win.id    = ID_W'(i);
                best_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/intc_hold.sv
module intc_hold
    import intc_pkg::*;
#(
    parameter int NSRC = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    input  logic                        rearm,
    output win_t                        held
);

    win_t arb_win;

    intc_arbiter #(.NSRC(NSRC)) u_arb (
        .cand (cand),
        .prio (prio),
        .win  (arb_win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (rearm) begin
            held <= '0;
        end else if (!held.valid && arb_win.valid) begin
            held <= arb_win;
        end
    end

    // R8: a held winner stays frozen until re-armed
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (held.valid && !rearm) |=> (held.valid && held.id == $past(held.id)));

    // R9: a re-arm always empties the path in the next cycle
    p_rearm_drop_r9: assert property (@(posedge clk) disable iff (rst)
        rearm |=> !held.valid);

    // R2: an idle path with a candidate picks it up at the next edge
    p_pickup_r2: assert property (@(posedge clk) disable iff (rst)
        (!held.valid && !rearm && (|cand)) |=> held.valid);

    // R10: nothing outside the implemented range is ever held
    p_in_range_r10: assert property (@(posedge clk) disable iff (rst)
        held.valid |-> (int'(held.id) < NSRC));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int NSRC   = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int HALF = MAX_SRC / 2;

    src_cfg_t                    cfg_q [NSRC];
    logic [MAX_SRC-1:0]          mask_q;
    logic [MAX_SRC-1:0]          keep_all;
    logic [MAX_SRC-1:0]          pend_ext;
    logic [NSRC-1:0]             pending;
    logic [NSRC-1:0]             edge_vec;
    logic [NSRC-1:0]             ack_vec;
    logic [NSRC-1:0]             cand_n;
    logic [NSRC-1:0]             cand_f;
    logic [NSRC-1:0][PRIO_W-1:0] prio_vec;
    logic                        rearm_n;
    logic                        rearm_f;
    win_t                        held_n;
    win_t                        held_f;

    function automatic logic hit(input logic [7:0] ofs);
        return bus_wr && (bus_addr == ADDR_W'(ofs));
    endfunction

    // ---------------- mask registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else begin
            if (hit(OFS_MASK_LO)) mask_q[HALF-1:0]       <= bus_wdata;
            if (hit(OFS_MASK_HI)) mask_q[MAX_SRC-1:HALF] <= bus_wdata;
        end
    end

    // ---------------- per-source configuration ----------------
    for (genvar i = 0; i < NSRC; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(OFS_CFG + 2 * i);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (bus_wr && bus_addr == CFG_ADDR) begin
                cfg_q[i] <= reg_to_cfg(bus_wdata);
            end
        end

        assign edge_vec[i] = cfg_q[i].edge_sel;
        assign prio_vec[i] = cfg_q[i].prio;
        assign cand_n[i]   = pending[i] && !mask_q[i] && (cfg_q[i].route == ROUTE_NORM);
        assign cand_f[i]   = pending[i] && !mask_q[i] && (cfg_q[i].route == ROUTE_FAST);
        assign ack_vec[i]  = (rearm_n && held_n.valid && held_n.id == ID_W'(i))
                          || (rearm_f && held_f.valid && held_f.id == ID_W'(i));
    end

    // ---------------- software clear of edge captures ----------------
    always_comb begin
        keep_all = '1;
        if (hit(OFS_PEND_LO)) keep_all[HALF-1:0]       = bus_wdata;
        if (hit(OFS_PEND_HI)) keep_all[MAX_SRC-1:HALF] = bus_wdata;
    end

    assign rearm_n = hit(OFS_CTRL) && bus_wdata[0];
    assign rearm_f = hit(OFS_CTRL) && bus_wdata[1];

    intc_capture #(.NSRC(NSRC)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .edge_sel (edge_vec),
        .keep     (keep_all[NSRC-1:0]),
        .ack      (ack_vec),
        .pending  (pending)
    );

    // ---------------- the two arbitration paths ----------------
    intc_hold #(.NSRC(NSRC)) u_hold_n (
        .clk   (clk),
        .rst   (rst),
        .cand  (cand_n),
        .prio  (prio_vec),
        .rearm (rearm_n),
        .held  (held_n)
    );

    intc_hold #(.NSRC(NSRC)) u_hold_f (
        .clk   (clk),
        .rst   (rst),
        .cand  (cand_f),
        .prio  (prio_vec),
        .rearm (rearm_f),
        .held  (held_f)
    );

    assign irq_o = held_n.valid;
    assign fiq_o = held_f.valid;

    // ---------------- read mux ----------------
    always_comb begin
        pend_ext             = '0;
        pend_ext[NSRC-1:0]   = pending;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_PEND_LO)) bus_rdata = pend_ext[HALF-1:0];
        if (bus_addr == ADDR_W'(OFS_PEND_HI)) bus_rdata = pend_ext[MAX_SRC-1:HALF];
        if (bus_addr == ADDR_W'(OFS_MASK_LO)) bus_rdata = mask_q[HALF-1:0];
        if (bus_addr == ADDR_W'(OFS_MASK_HI)) bus_rdata = mask_q[MAX_SRC-1:HALF];
        if (bus_addr == ADDR_W'(OFS_NUM_N))   bus_rdata = win_to_reg(held_n);
        if (bus_addr == ADDR_W'(OFS_NUM_F))   bus_rdata = win_to_reg(held_f);
        for (int i = 0; i < NSRC; i++) begin
            if (bus_addr == ADDR_W'(OFS_CFG + 2 * i)) bus_rdata = cfg_to_reg(cfg_q[i]);
        end
    end

    // R1: masks come out of reset all set
    p_mask_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1));

    // R9: re-arming one path leaves the other path's winner alone
    p_path_indep_r9: assert property (@(posedge clk) disable iff (rst)
        (rearm_n && !rearm_f && held_f.valid) |=> held_f.valid);

    // R7: an output is high only with a winner the source bus can name
    p_out_named_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (int'(held_n.id) < NSRC));

endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

    localparam int NSRC = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NSRC-1:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    prio_intc #(.NSRC(NSRC), .ADDR_W(8)) dut (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic quiet();
        src_in = '0;
        wr(8'h08, 16'hFFFF);
        wr(8'h0A, 16'hFFFF);
        wr(8'h14, 16'h0003);
        wr(8'h00, 16'h0000);
        wr(8'h02, 16'h0000);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd("R1 mask lo", 8'h08, 16'hFFFF);
        rd("R1 mask hi", 8'h0A, 16'hFFFF);
        rd("R1 pend lo", 8'h00, 16'h0000);
        rd("R1 pend hi", 8'h02, 16'h0000);
        rd("R1 num normal", 8'h10, 16'h0000);
        rd("R1 num fast", 8'h12, 16'h0000);
        rd("R1 ctrl", 8'h14, 16'h0000);
        check("R1 outputs", {14'd0, irq_o, fiq_o}, 16'h0000);
    endtask

    task automatic t_cfg_layout();
        wr(8'h2A, 16'h007F);
        rd("R3 cfg readback", 8'h2A, 16'h007F);
        wr(8'h2A, 16'hFFFF);
        rd("R3 upper bits zero", 8'h2A, 16'h007F);
        wr(8'h2A, 16'h0000);
    endtask

    task automatic t_level_mask();
        wr(8'h26, 16'h0010);               // source 3: prio 4, level, normal
        src_in[3] = 1'b1;
        rd("R4 level pending", 8'h00, 16'h0008);
        @(negedge clk); @(negedge clk);
        check("R2 masked no request", {15'd0, irq_o}, 16'h0000);
        wr(8'h08, 16'hFFF7);
        check("R2 latency one edge", {15'd0, irq_o}, 16'h0000);
        @(negedge clk);
        check("R2 unmasked request", {15'd0, irq_o}, 16'h0001);
        rd("R7 winner number", 8'h10, 16'h0003);
        src_in[3] = 1'b0;
        rd("R4 level follows input", 8'h00, 16'h0000);
        @(negedge clk);
        check("R8 held after input drop", {15'd0, irq_o}, 16'h0001);
        wr(8'h14, 16'h0001);
        check("R9 drop after rearm", {15'd0, irq_o}, 16'h0000);
        @(negedge clk);
        check("R9 no new winner", {15'd0, irq_o}, 16'h0000);
        rd("R7 number empty", 8'h10, 16'h0000);
        quiet();
    endtask

    task automatic t_edge_clear();
        wr(8'h44, 16'h001A);               // source 18: prio 6, edge, normal
        @(negedge clk); src_in[18] = 1'b1;
        @(negedge clk); src_in[18] = 1'b0;
        rd("R4 edge stays pending", 8'h02, 16'h0004);
        check("R2 masked edge no request", {15'd0, irq_o}, 16'h0000);
        wr(8'h02, 16'h0000);
        rd("R5 zero write clears", 8'h02, 16'h0000);
        @(negedge clk); src_in[18] = 1'b1;
        @(negedge clk); src_in[18] = 1'b0;
        wr(8'h02, 16'hFFFF);
        rd("R5 ones write keeps", 8'h02, 16'h0004);
        wr(8'h02, 16'hFFFB);
        rd("R5 selective clear", 8'h02, 16'h0000);
        quiet();
    endtask

    task automatic t_prio_freeze();
        wr(8'h24, 16'h001C);               // source 2: prio 7
        wr(8'h32, 16'h000C);               // source 9: prio 3
        wr(8'h38, 16'h000C);               // source 12: prio 3
        wr(8'h20, 16'h0000);               // source 0: prio 0
        src_in[2] = 1'b1; src_in[9] = 1'b1; src_in[12] = 1'b1;
        wr(8'h08, 16'hEDFB);
        @(negedge clk);
        rd("R6 lower prio and lower id win", 8'h10, 16'h0009);
        wr(8'h14, 16'h0001);
        @(negedge clk);
        rd("R6 level source wins again", 8'h10, 16'h0009);
        src_in[9] = 1'b0;
        wr(8'h14, 16'h0001);
        @(negedge clk);
        rd("R6 tie partner next", 8'h10, 16'h000C);
        src_in[0] = 1'b1;
        wr(8'h08, 16'hEDFA);
        @(negedge clk); @(negedge clk);
        rd("R8 frozen despite better", 8'h10, 16'h000C);
        wr(8'h14, 16'h0001);
        @(negedge clk);
        rd("R8 better after rearm", 8'h10, 16'h0000);
        check("R7 request with id 0", {15'd0, irq_o}, 16'h0001);
        quiet();
    endtask

    task automatic t_fast_path();
        wr(8'h48, 16'h0007);               // source 20: prio 1, edge, fast
        wr(8'h4A, 16'h0007);               // source 21: prio 1, edge, fast
        wr(8'h28, 16'h0000);               // source 4: prio 0, level, normal
        wr(8'h0A, 16'hFFCF);
        wr(8'h08, 16'hFFEF);
        @(negedge clk); src_in[21:20] = 2'b11;
        @(negedge clk); src_in[21:20] = 2'b00;
        @(negedge clk);
        check("R7 fast request", {15'd0, fiq_o}, 16'h0001);
        rd("R7 fast number", 8'h12, 16'h0014);
        check("R7 normal idle", {15'd0, irq_o}, 16'h0000);
        src_in[4] = 1'b1;
        @(negedge clk);
        rd("R7 normal number", 8'h10, 16'h0004);
        wr(8'h14, 16'h0002);
        check("R9 fast drops", {15'd0, fiq_o}, 16'h0000);
        check("R9 normal untouched", {15'd0, irq_o}, 16'h0001);
        rd("R9 normal number kept", 8'h10, 16'h0004);
        @(negedge clk);
        check("R9 fast rearbitrates", {15'd0, fiq_o}, 16'h0001);
        rd("R9 next fast winner", 8'h12, 16'h0015);
        rd("R9 ack cleared winner edge", 8'h02, 16'h0020);
        wr(8'h14, 16'h0002);
        @(negedge clk);
        check("R9 fast empty", {15'd0, fiq_o}, 16'h0000);
        rd("R9 all acked", 8'h02, 16'h0000);
        rd("R9 ctrl reads zero", 8'h14, 16'h0000);
        quiet();
    endtask

    task automatic t_unused();
        wr(8'h54, 16'h007F);               // source 26, above NSRC
        rd("R10 unused cfg reads zero", 8'h54, 16'h0000);
        wr(8'h0A, 16'h0000);
        @(negedge clk); @(negedge clk);
        rd("R10 unused pending zero", 8'h02, 16'h0000);
        check("R10 no winner", {14'd0, irq_o, fiq_o}, 16'h0000);
        quiet();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg_layout();
        t_level_mask();
        t_edge_clear();
        t_prio_freeze();
        t_fast_path();
        t_unused();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule